// File: doc/BRIEF.md
# Systolic Quadrature Amplitude Modulator Core

This block turns a stream of filtered in-phase and quadrature symbol words, one pair per clock, into modulated samples of the form I·cos + Q·sin. A phase accumulator adds a programmable step to a phase register on every clock. The phase addresses a sine table, and the cosine is read from the same table at an address a quarter period further on. The carrier samples enter a chain of identical stages and move one stage forward on each clock. The symbol words do not move along the chain. A slot counter steers each incoming pair into one stage, and that stage keeps the pair for a full rotation of the counter. Each stage therefore multiplies one symbol against a run of consecutive carrier samples. With the default settings that run is exactly one carrier period. Every stage produces its own registered result, so the chain accepts one symbol per clock rather than one per carrier period.

A small sequencer tracks how far the chain has filled. It starts in state FILL, where it records which stages have received their first symbol. At the edge that loads the last stage it takes the transition FILL→RUN. RUN is then held until reset, and in RUN every stage is reported as live. The phase step can be changed at any time, but the core only picks it up at the edge where the slot counter wraps. Symbols already in the chain keep the carrier rate they started with.

Top module: `qam_pipe_mod`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, every stage output is zero and `stage_live` is zero. The active phase step reverts to 2^PHASE_W/STAGES (64 by default), and the phase register and slot counter return to zero.
- R2: On every clock the phase register p advances by the active step, modulo 2^PHASE_W. The sine sample for p is round(2047·sin(2πp/1024)), rounded half away from zero. The cosine sample is the sine sample at address (p + 256) mod 1024.
- R3: Stage 0 captures the table samples for the current phase at each clock edge. Stage j>0 captures the samples that stage j−1 held before that edge.
- R4: The `phase_step` input becomes the active step only at the edge where the slot counter goes from STAGES−1 to 0. A value present at any other edge has no effect on the outputs.
- R5: The slot counter runs 0,1,…,STAGES−1 and then wraps. The symbol pair present at an edge with count j is loaded into stage j and held there for STAGES clocks.
- R6: After each edge, stage j's output (bits [16j+15:16j] of `stage_out`) is the top 16 bits of the 21-bit signed sum I·cos + Q·sin, formed from that stage's registers as they stood before the edge. The low 5 bits are discarded, which is truncation toward minus infinity.
- R7: In FILL, bit j of `stage_live` is set from the edge that first loads stage j. The sequencer takes FILL→RUN at the edge that loads stage STAGES−1 and stays in RUN, with `stage_live` all ones, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_step | input | PHASE_W (10) | Requested phase increment per clock |
| sym_i | input | SYM_W (8) | Filtered in-phase word, two's complement |
| sym_q | input | SYM_W (8) | Filtered quadrature word, two's complement |
| stage_out | output | STAGES·OUT_W (256) | Packed per-stage modulated samples, stage 0 in the low bits |
| stage_live | output | STAGES (16) | Per-stage flag: stage holds a loaded symbol |

## Verification
The assertions check on every cycle the properties that can be seen locally. A stage's symbol registers change only after its demultiplexer strobe. The active phase step changes only at a counter wrap. The counter returns to zero after its last slot. The fill mask is complete when RUN is entered. The bench sweeps the full symbol range and several phase steps, including a step that is not a power of two. It also toggles the requested step on every clock, and reasserts reset in the middle of a run. A cycle-by-cycle arithmetic model of the carrier samples and the truncated products shows that each symbol meets the right carrier samples and that ignored step values leave no trace in the outputs.

// File: rtl/qam_pkg.sv
package qam_pkg;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } qam_state_e;

    // Rounded sine amplitude, half away from zero
    function automatic int sine_code(input int k, input int depth, input int amp);
        real ang;
        real v;
        ang = 2.0 * 3.14159265358979323846 * real'(k) / real'(depth);
        v   = real'(amp) * $sin(ang);
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(-v + 0.5);
    endfunction

endpackage

// File: rtl/qam_sine_rom.sv
module qam_sine_rom #(
    parameter int PHASE_W      = 10,
    parameter int AMP_W        = 12,
    parameter bit SHARED_TABLE = 1'b1
) (
    input  logic [PHASE_W-1:0]      addr,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);
    localparam int DEPTH   = 1 << PHASE_W;
    localparam int QUARTER = DEPTH / 4;
    localparam int AMP     = (1 << (AMP_W - 1)) - 1;

    logic [PHASE_W-1:0] quad_addr;
    assign quad_addr = addr + PHASE_W'(QUARTER);

    generate
        if (SHARED_TABLE) begin : g_shared
            // One table, cosine read a quarter period ahead
            logic signed [AMP_W-1:0] tbl [DEPTH];
            initial begin
                for (int k = 0; k < DEPTH; k++)
                    tbl[k] = AMP_W'(qam_pkg::sine_code(k, DEPTH, AMP));
            end
            assign sin_o = tbl[addr];
            assign cos_o = tbl[quad_addr];
        end else begin : g_dual
            logic signed [AMP_W-1:0] sin_tbl [DEPTH];
            logic signed [AMP_W-1:0] cos_tbl [DEPTH];
            initial begin
                for (int k = 0; k < DEPTH; k++) begin
                    sin_tbl[k] = AMP_W'(qam_pkg::sine_code(k, DEPTH, AMP));
                    cos_tbl[k] = AMP_W'(qam_pkg::sine_code((k + QUARTER) % DEPTH, DEPTH, AMP));
                end
            end
            assign sin_o = sin_tbl[addr];
            assign cos_o = cos_tbl[addr];
        end
    endgenerate

endmodule

// File: rtl/qam_nco.sv
module qam_nco #(
    parameter int PHASE_W      = 10,
    parameter int AMP_W        = 12,
    parameter bit SHARED_TABLE = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PHASE_W-1:0]      step,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);
    logic [PHASE_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + step;
    end

    qam_sine_rom #(
        .PHASE_W      (PHASE_W),
        .AMP_W        (AMP_W),
        .SHARED_TABLE (SHARED_TABLE)
    ) u_rom (
        .addr  (phase_q),
        .sin_o (sin_o),
        .cos_o (cos_o)
    );

endmodule

// File: rtl/qam_ctrl.sv
module qam_ctrl #(
    parameter int STAGES  = 16,
    parameter int PHASE_W = 10,
    parameter int STEP_RST = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] step_in,
    output logic [PHASE_W-1:0] step_act,
    output logic [STAGES-1:0]  load_oh,
    output logic [STAGES-1:0]  live
);
    import qam_pkg::*;

    localparam int CNT_W = (STAGES > 1) ? $clog2(STAGES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STAGES - 1);

    qam_state_e        state_q, state_d;
    logic [CNT_W-1:0]  slot_q;
    logic [STAGES-1:0] fill_q;
    logic              wrap;

    assign wrap = (slot_q == LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (wrap) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    // Slot counter, step latch, fill mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q   <= '0;
            step_act <= PHASE_W'(STEP_RST);
            fill_q   <= '0;
        end else begin
            if (wrap) begin
                slot_q   <= '0;
                step_act <= step_in;
            end else begin
                slot_q <= slot_q + 1'b1;
            end
            if (state_q == ST_FILL) fill_q <= fill_q | load_oh;
        end
    end

    // Outputs
    always_comb begin
        load_oh         = '0;
        load_oh[slot_q] = 1'b1;
        unique case (state_q)
            ST_FILL: live = fill_q;
            ST_RUN:  live = '1;
            default: live = '0;
        endcase
    end

    p_step_wrap_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(step_act) |-> $past(wrap));

    p_slot_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (slot_q == '0));

    p_fill_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_RUN) |-> (&fill_q));

    p_run_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));

endmodule

// File: rtl/qam_stage.sv
module qam_stage #(
    parameter int SYM_W = 8,
    parameter int AMP_W = 12,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic signed [SYM_W-1:0] sym_i,
    input  logic signed [SYM_W-1:0] sym_q,
    input  logic signed [AMP_W-1:0] sin_in,
    input  logic signed [AMP_W-1:0] cos_in,
    output logic signed [AMP_W-1:0] sin_q,
    output logic signed [AMP_W-1:0] cos_q,
    output logic [OUT_W-1:0]        y_q
);
    localparam int PROD_W = SYM_W + AMP_W;
    localparam int SUM_W  = PROD_W + 1;

    logic signed [SYM_W-1:0]  i_r, q_r;
    logic signed [PROD_W-1:0] prod_i, prod_q;
    logic signed [SUM_W-1:0]  sum;

    assign prod_i = $signed({{AMP_W{i_r[SYM_W-1]}}, i_r}) * $signed({{SYM_W{cos_q[AMP_W-1]}}, cos_q});
    assign prod_q = $signed({{AMP_W{q_r[SYM_W-1]}}, q_r}) * $signed({{SYM_W{sin_q[AMP_W-1]}}, sin_q});
    assign sum    = {prod_i[PROD_W-1], prod_i} + {prod_q[PROD_W-1], prod_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sin_q <= '0;
            cos_q <= '0;
            i_r   <= '0;
            q_r   <= '0;
            y_q   <= '0;
        end else begin
            sin_q <= sin_in;
            cos_q <= cos_in;
            if (load) begin
                i_r <= sym_i;
                q_r <= sym_q;
            end
            y_q <= sum[SUM_W-1 -: OUT_W];
        end
    end

    p_sym_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(i_r) && $stable(q_r)));

endmodule

// File: rtl/qam_pipe_mod.sv
module qam_pipe_mod #(
    parameter int PHASE_W      = 10,
    parameter int STAGES       = 16,
    parameter int SYM_W        = 8,
    parameter int AMP_W        = 12,
    parameter int OUT_W        = 16,
    parameter bit SHARED_TABLE = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PHASE_W-1:0]        phase_step,
    input  logic [SYM_W-1:0]          sym_i,
    input  logic [SYM_W-1:0]          sym_q,
    output logic [STAGES*OUT_W-1:0]   stage_out,
    output logic [STAGES-1:0]         stage_live
);
    localparam int STEP_RST = (1 << PHASE_W) / STAGES;

    logic [PHASE_W-1:0]      step_act;
    logic [STAGES-1:0]       load_oh;
    logic signed [AMP_W-1:0] sin_chain [STAGES+1];
    logic signed [AMP_W-1:0] cos_chain [STAGES+1];

    qam_ctrl #(
        .STAGES   (STAGES),
        .PHASE_W  (PHASE_W),
        .STEP_RST (STEP_RST)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_in  (phase_step),
        .step_act (step_act),
        .load_oh  (load_oh),
        .live     (stage_live)
    );

    qam_nco #(
        .PHASE_W      (PHASE_W),
        .AMP_W        (AMP_W),
        .SHARED_TABLE (SHARED_TABLE)
    ) u_nco (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step_act),
        .sin_o (sin_chain[0]),
        .cos_o (cos_chain[0])
    );

    generate
        for (genvar j = 0; j < STAGES; j++) begin : g_stage
            qam_stage #(
                .SYM_W (SYM_W),
                .AMP_W (AMP_W),
                .OUT_W (OUT_W)
            ) u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .load   (load_oh[j]),
                .sym_i  (sym_i),
                .sym_q  (sym_q),
                .sin_in (sin_chain[j]),
                .cos_in (cos_chain[j]),
                .sin_q  (sin_chain[j+1]),
                .cos_q  (cos_chain[j+1]),
                .y_q    (stage_out[j*OUT_W +: OUT_W])
            );
        end
    endgenerate

    p_live_zero_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (stage_live == '0));

endmodule

// File: tb/tb_qam_pipe_mod.sv
module tb_qam_pipe_mod;
    localparam int CLK_PERIOD = 10;
    localparam int S      = 16;
    localparam int OW     = 16;
    localparam int DEPTH  = 1024;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [9:0]      phase_step = 10'd64;
    logic [7:0]      sym_i = '0;
    logic [7:0]      sym_q = '0;
    logic [S*OW-1:0] stage_out;
    logic [S-1:0]    stage_live;

    int n_checks = 0;
    int n_fails  = 0;

    // reference state
    int m_sin [S];
    int m_cos [S];
    int m_i   [S];
    int m_q   [S];
    int m_y   [S];
    int m_phase, m_slot, m_step;
    logic [S-1:0] m_live;
    bit  m_run;

    always #(CLK_PERIOD/2) clk = ~clk;

    qam_pipe_mod dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_step (phase_step),
        .sym_i      (sym_i),
        .sym_q      (sym_q),
        .stage_out  (stage_out),
        .stage_live (stage_live)
    );

    function automatic int sin_ref(input int p);
        real v;
        v = 2047.0 * $sin(2.0 * 3.14159265358979323846 * real'(p) / real'(DEPTH));
        if (v >= 0.0) return $rtoi(v + 0.5);
        else          return -$rtoi(-v + 0.5);
    endfunction

    function automatic int cos_ref(input int p);
        return sin_ref((p + 256) % DEPTH);
    endfunction

    task automatic model_reset();
        for (int j = 0; j < S; j++) begin
            m_sin[j] = 0; m_cos[j] = 0; m_i[j] = 0; m_q[j] = 0; m_y[j] = 0;
        end
        m_phase = 0; m_slot = 0; m_step = DEPTH / S; m_live = '0; m_run = 1'b0;
    endtask

    task automatic model_edge(input int iv, input int qv, input int req);
        for (int j = 0; j < S; j++)
            m_y[j] = (m_i[j] * m_cos[j] + m_q[j] * m_sin[j]) >>> 5;
        for (int j = S - 1; j > 0; j--) begin
            m_sin[j] = m_sin[j-1];
            m_cos[j] = m_cos[j-1];
        end
        m_sin[0] = sin_ref(m_phase);
        m_cos[0] = cos_ref(m_phase);
        m_i[m_slot] = iv;
        m_q[m_slot] = qv;
        if (!m_run) m_live[m_slot] = 1'b1;
        m_phase = (m_phase + m_step) % DEPTH;
        if (m_slot == S - 1) begin
            m_run  = 1'b1;
            m_step = req;
            m_slot = 0;
        end else begin
            m_slot = m_slot + 1;
        end
    endtask

    task automatic compare(input string tag);
        logic [S*OW-1:0] exp_flat;
        for (int j = 0; j < S; j++) exp_flat[j*OW +: OW] = OW'(m_y[j]);
        n_checks++;
        if (stage_out !== exp_flat) begin
            n_fails++;
            for (int j = 0; j < S; j++)
                if (stage_out[j*OW +: OW] !== exp_flat[j*OW +: OW]) begin
                    $display("FAIL %s stage %0d output: actual=%h expected=%h",
                             tag, j, stage_out[j*OW +: OW], exp_flat[j*OW +: OW]);
                    break;
                end
        end
        n_checks++;
        if (stage_live !== m_live) begin
            n_fails++;
            $display("FAIL R7 live mask: actual=%h expected=%h", stage_live, m_live);
        end
    endtask

    // drive at negedge, edge, sample at next negedge
    task automatic step(input int req, input int iv, input int qv, input string tag);
        phase_step = 10'(req);
        sym_i      = 8'(iv);
        sym_q      = 8'(qv);
        @(posedge clk);
        model_edge(iv, qv, req);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic check_reset_state();
        n_checks++;
        if (stage_out !== '0 || stage_live !== '0) begin
            n_fails++;
            $display("FAIL R1 reset state: actual out=%h live=%h expected=0", stage_out, stage_live);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_reset_state();
        model_reset();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state();                         // R1
        rst_n = 1'b1;

        // R7/R3: fill phase with a constant symbol
        for (int c = 0; c < 40; c++) step(64, 100, -50, "R3");

        // R5: sweep every in-phase value, quadrature mirrored
        for (int c = 0; c < 256; c++) step(64, c - 128, 127 - c, "R5");

        // R2: steps other than the default, one not a power of two
        for (int c = 0; c < 128; c++) step(192, (c * 37) % 256 - 128, (c * 11) % 256 - 128, "R2");
        for (int c = 0; c < 128; c++) step(100, (c * 53) % 256 - 128, (c * 29) % 256 - 128, "R2");

        // R4: requested step toggles each clock; only wrap values count
        for (int c = 0; c < 256; c++)
            step(((c % 3) == 0) ? 64 : ((c % 3) == 1) ? 320 : 5, (c * 7) % 256 - 128, (c * 13) % 256 - 128, "R4");

        // R6: extreme symbols for truncation
        for (int c = 0; c < 96; c++)
            step(64, (c[0]) ? 127 : -128, (c[1]) ? -128 : 127, "R6");

        // R1 mid-run reset, then refill
        do_reset();
        for (int c = 0; c < 48; c++) step(128, (c * 5) % 256 - 128, -((c * 3) % 128), "R7");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule